// File: doc/BRIEF.md
# General-Purpose I/O Port Group with Direction Control

This block gives a processor a small group of general-purpose pins on a simple memory-mapped register bus. It holds a configurable number of 8-bit bidirectional ports (three by default) and one 8-bit input-only port. Each bidirectional port has an output latch and a per-bit direction register. A direction bit of 1 turns that pin into an output driven from its latch bit. A direction bit of 0 leaves the pin as an input.

All pin inputs pass through a two-flop synchroniser before they reach the read path. Reading a data address returns a per-bit mix: the latch bit for pins set as outputs, and the synchronised pin level for pins set as inputs. Direction registers cannot be read; reading one returns all ones. Reset clears every direction bit, so all pins come up as inputs. Reset leaves the output latches untouched, so software is expected to write a latch before it turns any of its pins into outputs. One bit of the input-only port is also brought out on its own synchronised line, for use as an interrupt request source.

The register offsets are fixed by position. Bidirectional port data registers come first, at offsets 0 to 2. The input-only port follows at offset 3. The direction registers for the bidirectional ports come next, at offsets 4 to 6. Offset 7 is unused.

Top module: `gpio_port_group`

## Requirements
- R1: While reset is asserted, and on release from it, every output enable is 0 and `bus_rdata` is 0x00.
- R2: For each pin, `io_oe` equals that pin's direction bit. Wherever the enable is 1, `io_out` equals the latch bit. Both change on the clock edge that samples the direction or data write.
- R3: A write to a port's data offset loads all eight latch bits, including bits whose pins are currently inputs. Those bits later appear on `io_out` and in read data once their direction bits are set.
- R4: A read of a bidirectional port's data offset (port p at offset p) returns, per bit, the latch bit when the direction bit is 1 and the synchronised pin level when it is 0.
- R5: A read of any direction offset (port p at offset 4+p) returns 0xFF. A read of the unused offset 7 returns 0x00.
- R6: A read of offset 3 returns the synchronised input-only pins. A write to offset 3 changes no output enable and no read value.
- R7: `alt_irq` follows bit 6 of `in_only` after two clock edges. After one edge it still shows the old level.
- R8: `bus_rdata` is loaded on the clock edge that samples `bus_rd` high, and holds its value at every edge where `bus_rd` is low.
- R9: A direction write to one port leaves the direction bits and latches of the other ports unchanged.
- R10: A pin change first appears in read data for a read sampled on the third rising edge after the change. A read sampled on the second edge still returns the old level.
- R11: Reset does not alter an output latch. A value written before reset is driven once the direction bits are set after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | WIDTH (8) | Registered read data |
| io_in | input | NUM_BIDIR*WIDTH (24) | Pin levels of the bidirectional ports, port p at bits [8p+7:8p] |
| io_out | output | NUM_BIDIR*WIDTH (24) | Values driven onto the bidirectional pins |
| io_oe | output | NUM_BIDIR*WIDTH (24) | Per-pin output enables |
| in_only | input | WIDTH (8) | Pin levels of the input-only port |
| alt_irq | output | 1 | Synchronised copy of input-only bit 6 |

## Verification
Direction and latch writes reach `io_oe` and `io_out` on the same edge that samples the strobe. A reference model updates on that edge and is compared with both outputs at each falling clock edge. Read data arrives one edge after the read strobe, so read checks sample `bus_rdata` at the falling edge that follows. Pin changes reach the read path three edges after they are applied, and reach `alt_irq` two edges after. The bench therefore holds pins stable for three cycles before a read, except where it probes exactly the second and third edges to pin down R7 and R10.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_INONLY = 2'd2,
        SEL_DIR    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [7:0] idx;
    } reg_dec_t;

    // Offsets: data of bidirectional ports, then input-only port, then directions.
    function automatic reg_dec_t decode_offset(input int unsigned offs, input int unsigned nbid);
        reg_dec_t r;
        r.sel = SEL_NONE;
        r.idx = 8'd0;
        if (offs < nbid) begin
            r.sel = SEL_DATA;
            r.idx = 8'(offs);
        end else if (offs == nbid) begin
            r.sel = SEL_INONLY;
        end else if (offs <= 2 * nbid) begin
            r.sel = SEL_DIR;
            r.idx = 8'(offs - nbid - 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] out_val,
    output logic [W-1:0] out_en,
    output logic [W-1:0] rd_val
);

    typedef struct packed {
        logic [W-1:0] dir;
    } ctl_t;

    ctl_t         ctl_d, ctl_q;
    logic [W-1:0] lat_d, lat_q;

    always_comb begin
        ctl_d = ctl_q;
        lat_d = lat_q;
        if (wr_dir) begin
            ctl_d.dir = wdata;
        end
        if (wr_data) begin
            lat_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Output latch has no reset: it keeps its contents across reset.
    always_ff @(posedge clk) begin
        lat_q <= lat_d;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign rd_val[b] = ctl_q.dir[b] ? lat_q[b] : pin_sync[b];
    end

    assign out_val = lat_q;
    assign out_en  = ctl_q.dir;

    p_inputs_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> out_en == '0);

    p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> out_en == $past(wdata));

    p_latch_all_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> out_val == $past(wdata));

    p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(out_en));

endmodule

// File: rtl/gpio_port_group.sv
module gpio_port_group
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int NUM_BIDIR   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_BIT     = 6,
    parameter int ADDR_W      = $clog2(2 * NUM_BIDIR + 2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WIDTH-1:0]           bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [WIDTH-1:0]           bus_rdata,
    input  logic [NUM_BIDIR*WIDTH-1:0] io_in,
    output logic [NUM_BIDIR*WIDTH-1:0] io_out,
    output logic [NUM_BIDIR*WIDTH-1:0] io_oe,
    input  logic [WIDTH-1:0]           in_only,
    output logic                       alt_irq
);

    localparam int BUS_W = NUM_BIDIR * WIDTH;

    typedef struct packed {
        logic [WIDTH-1:0] rdata;
    } rd_state_t;

    reg_dec_t         dec;
    logic [BUS_W-1:0] bid_sync;
    logic [BUS_W-1:0] rd_all;
    logic [WIDTH-1:0] in_sync;
    logic [WIDTH-1:0] rd_mux;
    rd_state_t        st_d, st_q;

    assign dec = decode_offset(int'(bus_addr), NUM_BIDIR);

    gpio_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync_bid (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (io_in),
        .dout (bid_sync)
    );

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync_in (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_only),
        .dout (in_sync)
    );

    for (genvar p = 0; p < NUM_BIDIR; p++) begin : g_port
        logic wr_data_p, wr_dir_p;
        assign wr_data_p = bus_wr && (dec.sel == SEL_DATA) && (dec.idx == 8'(p));
        assign wr_dir_p  = bus_wr && (dec.sel == SEL_DIR)  && (dec.idx == 8'(p));

        gpio_bidir_port #(.W(WIDTH)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_data (wr_data_p),
            .wr_dir  (wr_dir_p),
            .wdata   (bus_wdata),
            .pin_sync(bid_sync[p*WIDTH +: WIDTH]),
            .out_val (io_out[p*WIDTH +: WIDTH]),
            .out_en  (io_oe[p*WIDTH +: WIDTH]),
            .rd_val  (rd_all[p*WIDTH +: WIDTH])
        );
    end

    always_comb begin
        rd_mux = '0;
        case (dec.sel)
            SEL_DATA: begin
                for (int p = 0; p < NUM_BIDIR; p++) begin
                    if (dec.idx == 8'(p)) begin
                        rd_mux = rd_all[p*WIDTH +: WIDTH];
                    end
                end
            end
            SEL_INONLY: rd_mux = in_sync;
            SEL_DIR:    rd_mux = '1;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign alt_irq   = in_sync[IRQ_BIT];

    p_dir_reads_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.sel == SEL_DIR) |=> bus_rdata == '1);

    p_unused_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec.sel == SEL_NONE) |=> bus_rdata == '0);

    p_inonly_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec.sel == SEL_INONLY) |=> $stable(io_oe));

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_gpio_port_group.sv
module tb_gpio_port_group;

    localparam int W  = 8;
    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [W-1:0]  bus_rdata;
    logic [NB*W-1:0] io_in = '0;
    logic [NB*W-1:0] io_out;
    logic [NB*W-1:0] io_oe;
    logic [W-1:0]  in_only = '0;
    logic          alt_irq;

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [W-1:0] m_dir [NB];
    logic [W-1:0] m_lat [NB];
    bit           m_lw  [NB];

    always #5 clk = ~clk;

    gpio_port_group dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .in_only(in_only), .alt_irq(alt_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: directions reset, latches persist; offsets 0..2 data, 4..6 direction.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NB; p++) m_dir[p] <= '0;
        end else if (bus_wr) begin
            if (bus_addr < 3) begin
                m_lat[bus_addr] <= bus_wdata;
                m_lw[bus_addr]  <= 1'b1;
            end else if (bus_addr >= 4 && bus_addr <= 6) begin
                m_dir[bus_addr - 4] <= bus_wdata;
            end
        end
    end

    // Per-clock comparison of enables and driven values (R2, R9)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NB; p++) begin
                chk("R2/R9 oe", 32'(io_oe[p*W +: W]), 32'(m_dir[p]));
                if (m_lw[p])
                    chk("R2 out", 32'(io_out[p*W +: W] & m_dir[p]), 32'(m_lat[p] & m_dir[p]));
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        for (int p = 0; p < NB; p++) begin m_lw[p] = 1'b0; m_lat[p] = '0; end
        io_in = {8'hF0, 8'h99, 8'h33};
        in_only = 8'h4C;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", 32'(io_oe), 32'h0);
        chk("R1 rdata in reset", 32'(bus_rdata), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", 32'(io_oe), 32'h0);

        // R3: latches written while all pins are inputs
        wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd2, 8'h0F);
        settle();
        rd(3'd0, v); chk("R4 all inputs A", 32'(v), 32'h33);

        wr(3'd4, 8'hF0);
        rd(3'd0, v); chk("R4 mixed A", 32'(v), 32'h53);

        rd(3'd4, v); chk("R5 dir A reads ones", 32'(v), 32'hFF);
        rd(3'd6, v); chk("R5 dir C reads ones", 32'(v), 32'hFF);
        rd(3'd7, v); chk("R5 unused reads zero", 32'(v), 32'h00);

        wr(3'd5, 8'hFF);
        rd(3'd1, v); chk("R4 all outputs B", 32'(v), 32'hC3);
        chk("R9 A dir unchanged", 32'(io_oe[7:0]), 32'hF0);

        wr(3'd0, 8'hA5);
        rd(3'd0, v); chk("R3 mixed after write", 32'(v), 32'hA3);
        wr(3'd4, 8'hFF);
        rd(3'd0, v); chk("R3 hidden bits latched", 32'(v), 32'hA5);
        chk("R3 out A", 32'(io_out[7:0]), 32'hA5);

        rd(3'd3, v); chk("R6 input-only read", 32'(v), 32'h4C);
        wr(3'd3, 8'hFF);
        rd(3'd3, v); chk("R6 write ignored", 32'(v), 32'h4C);
        chk("R6 oe unchanged", 32'(io_oe), 32'h00FFFF);

        // R7: alt_irq after two edges
        chk("R7 alt initial", 32'(alt_irq), 32'h1);
        @(negedge clk); in_only = 8'h0C;
        @(negedge clk); chk("R7 alt after one edge", 32'(alt_irq), 32'h1);
        @(negedge clk); chk("R7 alt after two edges", 32'(alt_irq), 32'h0);

        // R8: hold without read strobe
        rd(3'd2, v); chk("R8 read C", 32'(v), 32'hF0);
        io_in[23:16] = 8'h11;
        settle();
        chk("R8 rdata held", 32'(bus_rdata), 32'hF0);

        // R10: pin change timing on port C (inputs)
        @(negedge clk); io_in[23:16] = 8'h3C;
        @(negedge clk); bus_addr = 3'd2; bus_rd = 1'b1;
        @(negedge clk); chk("R10 second edge old", 32'(bus_rdata), 32'h11);
        @(negedge clk); chk("R10 third edge new", 32'(bus_rdata), 32'h3C);
        bus_rd = 1'b0;

        // R1, R11: reset mid-run, latch C kept
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 oe in second reset", 32'(io_oe), 32'h0);
        chk("R1 rdata in second reset", 32'(bus_rdata), 32'h0);
        rst_n = 1'b1;
        wr(3'd6, 8'hFF);
        chk("R11 latch kept across reset", 32'(io_out[23:16]), 32'h0F);
        rd(3'd2, v); chk("R11 read latch C", 32'(v), 32'h0F);

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule